// File: doc/BRIEF.md
# Conditional Execution Gate

This block decides whether an instruction is allowed to run by testing its 4-bit condition field against the four status flags: negative, zero, carry and overflow. A combinational evaluator turns the condition field and the flags into a pass bit. A registered stage takes a sample of the condition and the flags whenever a valid strobe is high, and returns the verdict one clock later.

Along with the verdict, the registered stage reports what the pipeline should do next. When the condition holds, the instruction executes. When it fails, the instruction is dropped, and its only effect is that the program counter moves on as usual, with no stall. Condition code 15 is reserved. It never passes, and it raises an illegal-condition flag.

The flags arrive on one 4-bit bus. Bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.

Top module: `cond_gate`

## Requirements
- R1: Code 0 passes when Z=1. Code 1 passes when Z=0.
- R2: Code 2 passes when C=1. Code 3 passes when C=0.
- R3: Code 4 passes when N=1 and code 5 passes when N=0. Code 6 passes when V=1 and code 7 passes when V=0.
- R4: Code 8 passes only when C=1 and Z=0. Code 9 passes when C=0 or Z=1, which is the exact complement of code 8.
- R5: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R6: Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R7: Code 14 passes for every combination of flag values.
- R8: Code 15 never passes. The registered illegal flag `illegal_o` is 1 only for a sample taken with code 15.
- R9: `valid_o` is 1 in exactly the cycle after a cycle in which `valid_i` was 1. In that cycle, `exec_en_o` carries the verdict for that sample.
- R10: `action_o` is 2'b01 (execute) for a passing sample and 2'b10 (advance the program counter, no other effect) for a failing sample. It is 2'b00 (idle) when `valid_o` is 0. In the idle case `exec_en_o` and `illegal_o` are both 0.
- R11: While `rst_ni` is low, `valid_o`, `exec_en_o` and `illegal_o` are 0, and `action_o` is 2'b00.
- R12: `pass_comb_o` gives, in the same cycle, the verdict for the current `cond_i` and `flags_i`, whatever the value of `valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample strobe for the condition and the flags |
| cond_i | input | 4 | Condition field |
| flags_i | input | 4 | Status flags: bit 3 N, bit 2 Z, bit 1 C, bit 0 V |
| pass_comb_o | output | 1 | Combinational verdict for the current inputs |
| valid_o | output | 1 | Registered result valid |
| exec_en_o | output | 1 | Registered execute enable |
| illegal_o | output | 1 | Registered reserved-condition flag |
| action_o | output | 2 | Next pipeline action: 00 idle, 01 execute, 10 advance |

## Verification
The hardest cases are the compound signed predicates (codes 12 and 13), which mix Z with the comparison of N and V. A bug there shows up only for particular flag combinations, for example Z=1 together with N equal to V. The stimulus therefore sweeps all 16 codes against all 16 flag values, so each compound term meets every operand combination. The sweep is then repeated as an unbroken burst of valid strobes, to show that back-to-back samples do not leak into each other.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
  localparam int unsigned COND_W    = 4;
  localparam int unsigned NUM_COND  = 1 << COND_W;
  localparam int unsigned NUM_PAIRS = 7;
  localparam int unsigned ALW_IDX   = 2 * NUM_PAIRS;
  localparam int unsigned RSV_IDX   = NUM_COND - 1;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [1:0] {
    ACT_IDLE    = 2'b00,
    ACT_EXEC    = 2'b01,
    ACT_ADVANCE = 2'b10
  } pipe_act_e;

  // even member of each complementary pair; odd member is its inverse
  function automatic logic pair_base(input int unsigned idx, input flags_t f);
    logic r;
    case (idx)
      0:       r = f.z;
      1:       r = f.c;
      2:       r = f.n;
      3:       r = f.v;
      4:       r = f.c & ~f.z;
      5:       r = ~(f.n ^ f.v);
      6:       r = ~f.z & ~(f.n ^ f.v);
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cond_flag_eval.sv
module cond_flag_eval
  import cond_eval_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              pass_o,
  output logic              rsv_o
);
  logic [NUM_COND-1:0] pass_vec;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pass_vec[2*p]   = pair_base(p, flags_i);
    assign pass_vec[2*p+1] = ~pass_vec[2*p];
  end

  assign pass_vec[ALW_IDX] = 1'b1;
  if (RSV_IDX != ALW_IDX) begin : g_rsv
    assign pass_vec[RSV_IDX] = 1'b0;
  end

  assign pass_o = pass_vec[cond_i];
  assign rsv_o  = (cond_i == COND_W'(RSV_IDX));

  always_comb begin
    // R8
    rsv_never_pass_chk: assert (!(rsv_o && pass_o));
  end
endmodule

// File: rtl/cond_result_reg.sv
module cond_result_reg
  import cond_eval_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  logic      pass_i,
  input  logic      rsv_i,
  output logic      valid_o,
  output logic      exec_en_o,
  output logic      illegal_o,
  output pipe_act_e action_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      exec_en_o <= 1'b0;
      illegal_o <= 1'b0;
      action_o  <= ACT_IDLE;
    end else begin
      valid_o   <= valid_i;
      exec_en_o <= valid_i & pass_i;
      illegal_o <= valid_i & rsv_i;
      if (!valid_i)    action_o <= ACT_IDLE;
      else if (pass_i) action_o <= ACT_EXEC;
      else             action_o <= ACT_ADVANCE;
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (action_o == ACT_IDLE && !exec_en_o && !illegal_o));
  // R10
  fail_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pass_i) |=> (action_o == ACT_ADVANCE && !exec_en_o));
endmodule

// File: rtl/cond_gate.sv
module cond_gate
  import cond_eval_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       pass_comb_o,
  output logic       valid_o,
  output logic       exec_en_o,
  output logic       illegal_o,
  output logic [1:0] action_o
);
  flags_t    flags;
  logic      rsv;
  pipe_act_e act;

  assign flags = flags_t'(flags_i);

  cond_flag_eval u_eval (
    .cond_i  (cond_i),
    .flags_i (flags),
    .pass_o  (pass_comb_o),
    .rsv_o   (rsv)
  );

  cond_result_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .pass_i    (pass_comb_o),
    .rsv_i     (rsv),
    .valid_o   (valid_o),
    .exec_en_o (exec_en_o),
    .illegal_o (illegal_o),
    .action_o  (act)
  );

  assign action_o = act;

  // R7
  always_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'd14) |=> exec_en_o);
  // R8
  reserved_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'd15) |=> (illegal_o && !exec_en_o));
  // R4
  hi_ls_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'd8 && flags_i[2]) |=> (action_o == 2'b10));
endmodule

// File: tb/cond_gate_bench.sv
module cond_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [3:0] cond = '0;
  logic [3:0] flags = '0;
  logic       pass_comb, valid_o, exec_en, illegal;
  logic [1:0] action;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  cond_gate u_cond_gate (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .cond_i(cond), .flags_i(flags),
    .pass_comb_o(pass_comb), .valid_o(valid_o), .exec_en_o(exec_en),
    .illegal_o(illegal), .action_o(action)
  );

  function automatic logic model_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd1:   return "R1";
      4'd2, 4'd3:   return "R2";
      4'd4, 4'd5, 4'd6, 4'd7: return "R3";
      4'd8, 4'd9:   return "R4";
      4'd10, 4'd11: return "R5";
      4'd12, 4'd13: return "R6";
      4'd14:        return "R7";
      default:      return "R8";
    endcase
  endfunction

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_registered(input logic [3:0] c, input logic [3:0] f);
    logic p;
    p = model_pass(c, f);
    cmp("R9", "valid_o", valid_o, 1);
    cmp(tag_of(c), "exec_en_o", exec_en, p);
    cmp("R10", "action_o", action, p ? 1 : 2);
    cmp("R8", "illegal_o", illegal, (c == 4'd15) ? 1 : 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    cmp("R11", "valid_o", valid_o, 0);
    cmp("R11", "exec_en_o", exec_en, 0);
    cmp("R11", "illegal_o", illegal, 0);
    cmp("R11", "action_o", action, 0);
  endtask

  // one strobe per vector with an idle cycle after it
  task automatic t_sweep_spaced();
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        @(negedge clk);
        cond = 4'(c); flags = 4'(f); valid = 1'b1;
        #1 cmp(tag_of(4'(c)), "pass_comb_o", pass_comb, model_pass(4'(c), 4'(f)));
        @(negedge clk);
        valid = 1'b0; cond = ~cond; flags = ~flags;
        check_registered(4'(c), 4'(f));
        #1 cmp("R12", "pass_comb_o idle", pass_comb, model_pass(cond, flags));
        @(negedge clk);
        cmp("R10", "idle action_o", action, 0);
        cmp("R10", "idle exec_en_o", exec_en, 0);
        cmp("R9", "idle valid_o", valid_o, 0);
      end
    end
  endtask

  // uninterrupted burst of strobes
  task automatic t_burst();
    logic [3:0] pc, pf;
    bit         have;
    have = 0; pc = '0; pf = '0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (have) check_registered(pc, pf);
      cond = 4'((k * 7) % 16); flags = 4'((k * 5 + k / 16) % 16); valid = 1'b1;
      pc = cond; pf = flags; have = 1;
    end
    @(negedge clk);
    valid = 1'b0;
    check_registered(pc, pf);
    @(negedge clk);
    cmp("R9", "post-burst valid_o", valid_o, 0);
  endtask

  task automatic t_reset_midstream();
    @(negedge clk);
    cond = 4'd14; flags = 4'h0; valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    cmp("R11", "async valid_o", valid_o, 0);
    cmp("R11", "async exec_en_o", exec_en, 0);
    cmp("R11", "async action_o", action, 0);
    @(negedge clk);
    valid = 1'b0; rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sweep_spaced();
    t_burst();
    t_reset_midstream();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule